// File: doc/BRIEF.md
# External-Access Wait-State Generator

This block stretches external bus accesses by a programmable number of wait states. When an access begins, the bus controller pulses a start strobe. The strobe carries a 2-bit space code and an 18-bit address. The block finds the region the access falls in, takes that region's 3-bit base count from a 16-bit configuration register, and doubles the count when the multiplier bit is set. It then holds a not-ready output high for exactly that many clock cycles. The bus controller holds the access while not-ready is high.

Software sets the block up through a plain register port. A write strobe, an 8-bit register address and 16 bits of write data write a register. The read data follows the register address combinationally. The configuration register sits at address 28h and the control register at 2Bh.

The configuration register holds one field per region:

| Bits | Region |
|------|--------|
| 2:0 | lower program |
| 5:3 | upper program |
| 8:6 | lower data |
| 11:9 | upper data |
| 14:12 | I/O |

Bit 15 of the configuration register is the extended-program bit. Bit 0 of the control register is the multiplier.

The strobe and the not-ready output form a simple stall handshake and not a buffered stream. An access is accepted only while not-ready is low. The caller must not start another access until not-ready has fallen, because a strobe that arrives during a stall is dropped. The block latches the wait count when it accepts an access, so register writes only shape later accesses.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, the configuration register reads 1249h (every 3-bit field 1, extended-program bit 0) and the control register reads 0000h. A data access made in that state stalls for 1 cycle.
- R2: Writing address 28h stores all 16 bits, and address 28h reads them back. Reading any address other than 28h or 2Bh returns 0000h.
- R3: At address 2Bh only bit 0 is writable. Bits 15:1 always read 0, whatever is written to them.
- R4: An access with space code 2 (I/O) uses bits 14:12 for any address. Address bits 17:16 are ignored.
- R5: An access with space code 1 (data) behaves as follows. If address bit 15 is 1, it uses bits 11:9. If address bit 15 is 0, it uses bits 8:6. Address bits 17:16 are ignored.
- R6: An access with space code 0 (program) and extended-program bit 0 selects its field from address bit 15. If bit 15 is 1, it uses bits 5:3. If bit 15 is 0, it uses bits 2:0. Address bits 17:16 play no part.
- R7: An access with space code 0 and extended-program bit 1 uses bits 2:0 for every address from 00000h to 3FFFFh. Bits 5:3 then have no effect.
- R8: With control bit 0 set, the wait count is twice the base field value, at most 14. With control bit 0 clear, the wait count equals the field value.
- R9: An accepted start strobe with wait count N drives not-ready high for exactly N cycles, starting in the cycle after the clock edge that samples the strobe. When N is 0, not-ready stays low.
- R10: A start strobe sampled while not-ready is high is ignored. The stall in progress keeps its length, and no new stall follows it.
- R11: A register write made during a stall leaves that stall's length unchanged. The next access uses the new value.
- R12: Space code 3 is reserved and gives a wait count of 0, so there is no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (28h configuration, 2Bh control) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| acc_start | input | 1 | Access start strobe, one cycle |
| acc_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 reserved |
| acc_addr | input | 18 | Access address |
| acc_not_ready | output | 1 | High while the access is being stalled |

## Verification
Register read data is combinational, so the bench samples it a moment after it sets the address, within the same cycle. A stall begins at the first falling edge after the rising edge that samples the strobe. The scoreboard monitor arms itself at that rising edge and then counts the falling edges at which not-ready is high. It compares the total with the queued expectation at the first falling edge where not-ready is low. An expectation of zero is therefore settled at the first falling edge after the strobe. For dropped strobes, the bench also watches several idle falling edges afterwards to confirm that no stray stall appears.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int FIELD_W    = 3;
  localparam int NUM_FIELDS = 5;
  localparam int CFG_W      = 16;
  localparam int XPROG_BIT  = 15;
  localparam int CNT_W      = FIELD_W + 1;

  typedef enum logic [1:0] {
    SPACE_PROG = 2'd0,
    SPACE_DATA = 2'd1,
    SPACE_IO   = 2'd2,
    SPACE_RSVD = 2'd3
  } space_e;

  // Region index equals the field index in the configuration register.
  typedef enum logic [2:0] {
    RG_PROG_LO = 3'd0,
    RG_PROG_HI = 3'd1,
    RG_DATA_LO = 3'd2,
    RG_DATA_HI = 3'd3,
    RG_IO      = 3'd4,
    RG_NONE    = 3'd5
  } region_e;
endpackage

// File: rtl/wsg_regs.sv
module wsg_regs
  import wsg_pkg::*;
#(
  parameter int RADDR_W = 8,
  parameter logic [RADDR_W-1:0] CFG_ADDR = 8'h28,
  parameter logic [RADDR_W-1:0] CTL_ADDR = 8'h2B,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h1249
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [RADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]   wdata,
  output logic [CFG_W-1:0]   rdata,
  output logic [CFG_W-1:0]   cfg,
  output logic               mul
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
      mul <= 1'b0;
    end else if (wr) begin
      if (addr == CFG_ADDR) cfg <= wdata;
      if (addr == CTL_ADDR) mul <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CFG_ADDR)      rdata = cfg;
    else if (addr == CTL_ADDR) rdata = {{(CFG_W-1){1'b0}}, mul};
  end
endmodule

// File: rtl/wsg_decode.sv
module wsg_decode
  import wsg_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LOCAL_W = 16
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic              mul,
  input  logic [1:0]        space,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [CNT_W-1:0]  eff
);
  logic [FIELD_W-1:0] fields [NUM_FIELDS];
  logic [FIELD_W-1:0] base;
  logic               upper_half;
  logic               xprog;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      assign fields[gi] = cfg[gi*FIELD_W +: FIELD_W];
    end
  endgenerate

  assign upper_half = addr[LOCAL_W-1];
  assign xprog      = cfg[XPROG_BIT];

  always_comb begin
    unique case (space_e'(space))
      SPACE_PROG: region = (xprog || !upper_half) ? RG_PROG_LO : RG_PROG_HI;
      SPACE_DATA: region = upper_half ? RG_DATA_HI : RG_DATA_LO;
      SPACE_IO:   region = RG_IO;
      default:    region = RG_NONE;
    endcase
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (region == region_e'(i)) base = fields[i];
  end

  assign eff = mul ? {base, 1'b0} : {1'b0, base};
endmodule

// File: rtl/wsg_counter.sv
module wsg_counter
  import wsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] remain,
  output logic             not_ready
);
  logic idle;
  assign idle = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start && idle)  remain <= load;
    else if (!idle)          remain <= remain - 1'b1;
  end

  assign not_ready = !idle;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LOCAL_W = 16,
  parameter int RADDR_W = 8,
  parameter logic [RADDR_W-1:0] CFG_ADDR = 8'h28,
  parameter logic [RADDR_W-1:0] CTL_ADDR = 8'h2B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               acc_start,
  input  logic [1:0]         acc_space,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               acc_not_ready
);
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h1249;

  logic [CFG_W-1:0] cfg;
  logic             mul;
  region_e          region;
  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] remain;

  wsg_regs #(
    .RADDR_W(RADDR_W), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR), .CFG_RESET(CFG_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .mul(mul)
  );

  wsg_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) u_dec (
    .cfg(cfg), .mul(mul), .space(acc_space), .addr(acc_addr),
    .region(region), .eff(eff)
  );

  wsg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .load(eff),
    .remain(remain), .not_ready(acc_not_ready)
  );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker
  import wsg_pkg::*;
#(
  parameter int RADDR_W = 8,
  parameter logic [RADDR_W-1:0] CTL_ADDR = 8'h2B
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RADDR_W-1:0] reg_addr,
  input logic [15:0]        reg_rdata,
  input logic               acc_start,
  input logic [1:0]         acc_space,
  input logic               acc_not_ready,
  input logic               mul,
  input logic [CNT_W-1:0]   eff,
  input logic [CNT_W-1:0]   remain
);
  assert_ctl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_ADDR) |-> (reg_rdata[15:1] == '0));

  assert_single_mul_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mul |-> (eff <= 7));

  assert_double_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mul |-> (eff[0] == 1'b0));

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_not_ready) |-> $past(acc_start));

  assert_zero_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !acc_not_ready && eff == '0) |=> !acc_not_ready);

  assert_load_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !acc_not_ready && eff != '0) |=> (acc_not_ready && remain == $past(eff)));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_not_ready && remain > 1) |=> (acc_not_ready && remain == $past(remain) - 1'b1));

  assert_rsvd_space_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_space == 2'd3) |-> (eff == '0));
endmodule

bind wait_state_gen wsg_checker #(.RADDR_W(RADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .acc_start(acc_start), .acc_space(acc_space), .acc_not_ready(acc_not_ready),
  .mul(mul), .eff(eff), .remain(remain)
);

// File: tb/wait_state_gen_test.sv
module wait_state_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        acc_start = 1'b0;
  logic [1:0]  acc_space = 2'd0;
  logic [17:0] acc_addr = 18'h0;
  logic        acc_not_ready;

  int checks = 0;
  int fails  = 0;

  int    exp_q[$];
  string tag_q[$];
  logic  exp_flag = 1'b0;
  bit    active = 1'b0;
  int    run = 0;

  always #5 clk = ~clk;

  wait_state_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_start(acc_start),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_not_ready(acc_not_ready)
  );

  task automatic chk(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: arm on an expected strobe, count stall cycles, compare.
  always @(posedge clk) begin
    if (acc_start && exp_flag) begin
      active = 1'b1;
      run = 0;
    end
  end

  always @(negedge clk) begin
    if (active) begin
      if (acc_not_ready) run++;
      else begin
        active = 1'b0;
        chk(run, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input int expv, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(int'(reg_rdata), expv, tag);
  endtask

  // Driver: push expectation, issue strobe, wait for the scoreboard.
  task automatic do_access(input logic [1:0] sp, input logic [17:0] ad,
                           input int expn, input string tag);
    @(negedge clk);
    acc_space = sp; acc_addr = ad; acc_start = 1'b1; exp_flag = 1'b1;
    exp_q.push_back(expn); tag_q.push_back(tag);
    @(negedge clk);
    acc_start = 1'b0; exp_flag = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check_idle(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(int'(acc_not_ready), 0, tag);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(int'(acc_not_ready), 0, "R1 not_ready at reset");
    rst_n = 1'b1;

    reg_check(8'h28, 16'h1249, "R1 cfg reset");
    reg_check(8'h2B, 16'h0000, "R1 ctl reset");
    do_access(2'd1, 18'h08000, 1, "R1 default data wait");

    reg_write(8'h28, 16'h5A3C);
    reg_check(8'h28, 16'h5A3C, "R2 cfg readback");
    reg_check(8'h10, 16'h0000, "R2 unmapped read");

    reg_write(8'h2B, 16'hFFFF);
    reg_check(8'h2B, 16'h0001, "R3 reserved bits set");
    reg_write(8'h2B, 16'hFFFE);
    reg_check(8'h2B, 16'h0000, "R3 reserved bits clear");

    // io=5 dhi=4 dlo=3 phi=2 plo=6, extended-program bit 0
    reg_write(8'h28, 16'h58D6);
    do_access(2'd2, 18'h00000, 5, "R4 io low");
    do_access(2'd2, 18'h3FFFF, 5, "R4 io high");
    do_access(2'd1, 18'h07FFF, 3, "R5 data lower");
    do_access(2'd1, 18'h08000, 4, "R5 data upper");
    do_access(2'd1, 18'h28000, 4, "R5 data high bits ignored");
    do_access(2'd0, 18'h00000, 6, "R6 prog lower");
    do_access(2'd0, 18'h07FFF, 6, "R6 prog lower edge");
    do_access(2'd0, 18'h08000, 2, "R6 prog upper");
    do_access(2'd0, 18'h3FFFF, 2, "R6 prog upper top");
    do_access(2'd0, 18'h10000, 6, "R6 prog bit16 ignored");
    do_access(2'd3, 18'h08000, 0, "R12 reserved space");
    check_idle(2, "R12 no stall");

    reg_write(8'h28, 16'hD8D6);
    do_access(2'd0, 18'h08000, 6, "R7 xprog upper uses low field");
    do_access(2'd0, 18'h3FFFF, 6, "R7 xprog top");
    do_access(2'd1, 18'h08000, 4, "R7 data unaffected");

    reg_write(8'h2B, 16'h0001);
    reg_write(8'h28, 16'h58D6);
    do_access(2'd2, 18'h01234, 10, "R8 io doubled");
    do_access(2'd0, 18'h00010, 12, "R8 prog doubled");
    reg_write(8'h28, 16'h7FFF);
    do_access(2'd2, 18'h0FFFF, 14, "R8 maximum 14");
    reg_write(8'h28, 16'h0000);
    do_access(2'd1, 18'h00000, 0, "R9 zero wait");
    check_idle(2, "R9 zero no stall");

    reg_write(8'h28, 16'h7FFF);
    fork
      do_access(2'd2, 18'h00000, 14, "R10 stall length kept");
      begin
        repeat (4) @(negedge clk);
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
      end
    join
    check_idle(4, "R10 no extra stall");

    reg_write(8'h2B, 16'h0000);
    reg_write(8'h28, 16'h7000);
    fork
      do_access(2'd2, 18'h00000, 7, "R11 current stall unchanged");
      begin
        repeat (3) @(negedge clk);
        reg_addr = 8'h28; reg_wdata = 16'h2000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
      end
    join
    do_access(2'd2, 18'h00000, 2, "R11 next access uses new value");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule